// File: doc/BRIEF.md
# Phase-Shifted Carrier Level Modulator

This block produces the signed step command for a nine-level single-phase inverter. A phase accumulator advances by a programmable step every clock and drives a quarter-wave sine table. The table output is scaled by a modulation index to form the reference. The magnitude of the reference is compared against a bank of equal triangular carriers. The carriers share one period and one amplitude, and their phases are spread evenly over a full carrier cycle. The output magnitude is the number of carriers that the rectified reference beats. The sign of the reference chooses the polarity. With the default of four carriers the output therefore runs from -4 to +4.

The carrier half-period and the fundamental step are inputs, so the frequency ratio is set at run time. A 50 MHz clock with a half-period of 25000 and a step of 4295 on a 32-bit accumulator gives a 1 kHz carrier and a 50 Hz fundamental, a ratio of 20. Modulation indices above unity are accepted. In that region the reference clips at full scale, and a clipped reference beats every carrier. The level and the polarity flag are registered, and a new value appears every clock. Turning the level into switch gate signals is left to a later stage.

Top module: `pscm_level_mod`

## Requirements
- R1: While `rst` is high at a rising edge, the next output is `level_o` = 0 and `half_neg` = 0. Reset also clears the phase accumulator to 0 and loads every carrier phase counter with its start offset.
- R2: The phase accumulator adds `fund_step` on every clock out of reset. Its top two bits form the quadrant q. The QB=8 bits below the quadrant form the table index i. Quadrants 0 and 1 are the positive half, and quadrants 2 and 3 are the negative half.
- R3: The table entry i (0..255) equals round(65535 * sin(pi*(2i+1)/1024)). In quadrants 0 and 2 the table is read at i. In quadrants 1 and 3 it is read at 255-i.
- R4: The reference magnitude is m = floor(entry * mod_idx / 64), so `mod_idx` is unsigned with 64 meaning 1.0. When m exceeds 65535 it is replaced by 65536.
- R5: Each carrier has a phase counter p running 0 .. 2H-1 and then wrapping to 0, where H = `car_half` (H >= 1). The carrier value is p when p < H and 2H-p otherwise, so it peaks at H.
- R6: At reset, carrier k (k = 0 .. N-1, with N carriers) starts at phase floor(k*2H/N).
- R7: The magnitude equals the number of carriers k for which m*H > c_k*65535. It is computed from the accumulator and counter state of one cycle and appears on the outputs after the following rising edge.
- R8: `level_o` is +magnitude, or -magnitude when the reference is negative. The reference is negative when q is 2 or 3 and m is non-zero, and `half_neg` is 1 exactly then. A zero reference gives level 0 with `half_neg` = 0. The level always lies in -N..N.
- R9: Over-modulation (`mod_idx` > 64) is allowed. A reference clipped to 65536 beats every carrier, including a carrier at its peak, so the level reaches +N and -N.
- R10: With N = 3 carriers the start phases are one third of a carrier period apart (120 degrees), and the level lies in -3..3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mod_idx | input | MI_W (8) | Modulation index, unsigned, 64 = 1.0 |
| car_half | input | CW (16) | Carrier half-period H in clocks |
| fund_step | input | PH_W (32) | Phase accumulator increment per clock |
| level_o | output | LW (4) | Signed level command, -N..N |
| half_neg | output | 1 | 1 when the reference is negative |

## Verification
The bench builds two copies of the block side by side, one with four carriers and one with three. Both use a 12-bit phase accumulator, so a full fundamental lasts only 4096/step clocks. Carrier half-periods are 5 to 7 clocks, so every sine quadrant, every table mirror point and every carrier crossing is reached within a few hundred cycles. Odd and even half-periods exercise the floor in the start offsets. The three-carrier copy covers the 120-degree spacing. Zero, nominal, low, over-modulated and saturating indices are compared cycle by cycle against an arithmetic model.

// File: rtl/pscm_pkg.sv
package pscm_pkg;

    // Sine table geometry
    localparam int SW  = 16;             // table sample width
    localparam int QB  = 8;              // quarter-wave index bits
    localparam int QN  = 1 << QB;        // quarter-wave entries
    localparam int AMP = (1 << SW) - 1;  // full-scale sample

    localparam real PI_R = 3.14159265358979323846;

    // Rectified reference together with its sign
    typedef struct packed {
        logic          neg;
        logic [SW:0]   mag;   // 0 .. AMP+1 (AMP+1 marks a clipped reference)
    } ref_t;

    // Quarter-wave sample at the middle of slot i
    function automatic int sine_entry(input int i);
        real x;
        x = PI_R * (2.0 * real'(i) + 1.0) / (4.0 * real'(QN));
        return $rtoi(real'(AMP) * $sin(x) + 0.5);
    endfunction

endpackage

// File: rtl/pscm_ref_gen.sv
module pscm_ref_gen
    import pscm_pkg::*;
#(
    parameter int PH_W    = 32,
    parameter int MI_W    = 8,
    parameter int MI_FRAC = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PH_W-1:0] fund_step,
    input  logic [MI_W-1:0] mod_idx,
    output ref_t            ref_o
);

    localparam int PW = SW + MI_W;

    logic [PH_W-1:0] acc;
    logic [1:0]      quad;
    logic [QB-1:0]   idx;
    logic [QB-1:0]   look;
    logic [SW-1:0]   rom [QN];
    logic [SW-1:0]   samp;
    logic [PW-1:0]   prod;
    logic [PW-1:0]   scaled;
    logic [SW:0]     mag;

    // Phase accumulator
    always_ff @(posedge clk) begin
        if (rst) acc <= '0;
        else     acc <= acc + fund_step;
    end

    // Quarter-wave table, filled at elaboration
    for (genvar g = 0; g < QN; g++) begin : g_rom
        localparam int VAL = sine_entry(g);
        assign rom[g] = SW'(VAL);
    end

    assign quad = acc[PH_W-1 -: 2];
    assign idx  = acc[PH_W-3 -: QB];

    if (PH_W > QB + 2) begin : g_lsb
        logic lsb_unused;
        assign lsb_unused = ^acc[PH_W-QB-3:0];
    end

    // Odd quadrants read the table backwards
    assign look = quad[0] ? ~idx : idx;
    assign samp = rom[look];

    // Scale by the modulation index, then clip
    assign prod   = PW'(samp) * PW'(mod_idx);
    assign scaled = prod >> MI_FRAC;

    always_comb begin
        if (scaled > PW'(AMP)) mag = (SW+1)'(AMP + 1);
        else                   mag = scaled[SW:0];
    end

    assign ref_o.mag = mag;
    assign ref_o.neg = quad[1] && (mag != '0);

endmodule

// File: rtl/pscm_carrier_bank.sv
module pscm_carrier_bank #(
    parameter int N_CAR = 4,
    parameter int CW    = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] car_half,
    output logic [CW-1:0] car_o [N_CAR]
);

    localparam int OW = CW + 2 + $clog2(N_CAR + 1);

    logic [CW:0] span;
    logic [CW:0] last;

    assign span = {car_half, 1'b0};
    assign last = span - 1'b1;

    for (genvar g = 0; g < N_CAR; g++) begin : g_car
        logic [OW-1:0] start;
        logic [CW:0]   ph;

        // Evenly spread start phase over one carrier period
        assign start = (OW'(g) * OW'(span)) / OW'(N_CAR);

        always_ff @(posedge clk) begin
            if (rst)             ph <= start[CW:0];
            else if (ph >= last) ph <= '0;
            else                 ph <= ph + 1'b1;
        end

        // Fold the phase into a triangle that peaks at car_half
        always_comb begin
            if (ph < {1'b0, car_half}) car_o[g] = ph[CW-1:0];
            else if (ph <= span)       car_o[g] = CW'(span - ph);
            else                       car_o[g] = '0;
        end
    end

endmodule

// File: rtl/pscm_level_sum.sv
module pscm_level_sum
    import pscm_pkg::*;
#(
    parameter int N_CAR = 4,
    parameter int CW    = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  ref_t                ref_i,
    input  logic [CW-1:0]       car_half,
    input  logic [CW-1:0]       car_i [N_CAR],
    output logic signed [$clog2(N_CAR+1):0] level_o,
    output logic                half_neg
);

    localparam int CNTW = $clog2(N_CAR + 1);
    localparam int LW   = CNTW + 1;
    localparam int XW   = SW + CW + 1;

    logic [XW-1:0]        lhs;
    logic [CNTW-1:0]      cnt;
    logic signed [LW-1:0] mag_s;
    logic signed [LW-1:0] lvl_d;

    // Reference scaled into carrier units by cross-multiplication
    assign lhs = XW'(ref_i.mag) * XW'(car_half);

    always_comb begin
        cnt = '0;
        for (int k = 0; k < N_CAR; k++) begin
            if (lhs > XW'(car_i[k]) * XW'(AMP)) cnt = cnt + CNTW'(1);
        end
    end

    assign mag_s = $signed({1'b0, cnt});
    assign lvl_d = ref_i.neg ? -mag_s : mag_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            level_o  <= '0;
            half_neg <= 1'b0;
        end else begin
            level_o  <= lvl_d;
            half_neg <= ref_i.neg;
        end
    end

endmodule

// File: rtl/pscm_level_mod.sv
module pscm_level_mod
    import pscm_pkg::*;
#(
    parameter int N_CAR   = 4,
    parameter int PH_W    = 32,
    parameter int CW      = 16,
    parameter int MI_W    = 8,
    parameter int MI_FRAC = 6
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [MI_W-1:0]                 mod_idx,
    input  logic [CW-1:0]                   car_half,
    input  logic [PH_W-1:0]                 fund_step,
    output logic signed [$clog2(N_CAR+1):0] level_o,
    output logic                            half_neg
);

    ref_t          ref_w;
    logic [CW-1:0] car_val [N_CAR];

    pscm_ref_gen #(
        .PH_W   (PH_W),
        .MI_W   (MI_W),
        .MI_FRAC(MI_FRAC)
    ) u_ref (
        .clk      (clk),
        .rst      (rst),
        .fund_step(fund_step),
        .mod_idx  (mod_idx),
        .ref_o    (ref_w)
    );

    pscm_carrier_bank #(
        .N_CAR(N_CAR),
        .CW   (CW)
    ) u_car (
        .clk     (clk),
        .rst     (rst),
        .car_half(car_half),
        .car_o   (car_val)
    );

    pscm_level_sum #(
        .N_CAR(N_CAR),
        .CW   (CW)
    ) u_sum (
        .clk     (clk),
        .rst     (rst),
        .ref_i   (ref_w),
        .car_half(car_half),
        .car_i   (car_val),
        .level_o (level_o),
        .half_neg(half_neg)
    );

endmodule

// File: rtl/pscm_level_mod_chk.sv
module pscm_level_mod_chk #(
    parameter int N_CAR = 4,
    parameter int CW    = 16,
    parameter int MI_W  = 8
) (
    input logic                            clk,
    input logic                            rst,
    input logic [MI_W-1:0]                 mod_idx,
    input logic [CW-1:0]                   car_half,
    input logic signed [$clog2(N_CAR+1):0] level_o,
    input logic                            half_neg,
    input logic [CW-1:0]                   car_val [N_CAR]
);

    logic was_rst = 1'b0;

    always_ff @(posedge clk) was_rst <= rst;

    // R1: an edge in reset leaves a cleared output
    always @(negedge clk) begin
        if (was_rst) begin
            a_r1_reset_clear: assert (level_o == 0 && !half_neg)
                else $error("reset did not clear the level");
        end
    end

    // R5: no carrier rises above its peak
    always @(negedge clk) begin
        if (!rst && !was_rst) begin
            for (int k = 0; k < N_CAR; k++) begin
                a_r5_peak_bound: assert (car_val[k] <= car_half)
                    else $error("carrier %0d above peak", k);
            end
        end
    end

    a_r8_level_range: assert property (@(posedge clk) disable iff (rst)
        (level_o >= -N_CAR && level_o <= N_CAR));

    a_r8_neg_side: assert property (@(posedge clk) disable iff (rst)
        half_neg |-> (level_o <= 0));

    a_r8_pos_side: assert property (@(posedge clk) disable iff (rst)
        !half_neg |-> (level_o >= 0));

    a_r8_zero_index: assert property (@(posedge clk) disable iff (rst)
        (mod_idx == '0) |=> (level_o == 0 && !half_neg));

endmodule

bind pscm_level_mod pscm_level_mod_chk #(
    .N_CAR(N_CAR),
    .CW   (CW),
    .MI_W (MI_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .mod_idx (mod_idx),
    .car_half(car_half),
    .level_o (level_o),
    .half_neg(half_neg),
    .car_val (car_val)
);

// File: tb/pscm_level_mod_tb_top.sv
`timescale 1ns/1ps
module pscm_level_mod_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  mod_idx = '0;
    logic [15:0] car_half = 16'd6;
    logic [11:0] fund_step = '0;

    logic signed [3:0] lvl4;
    logic              neg4;
    logic signed [2:0] lvl3;
    logic              neg3;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit done  = 0;
    int tab [256];
    int max4, min4, max3, min3, nonzero;

    always #10 clk = ~clk;   // 50 MHz

    pscm_level_mod #(.N_CAR(4), .PH_W(12), .CW(16)) dut_i (
        .clk(clk), .rst(rst), .mod_idx(mod_idx), .car_half(car_half),
        .fund_step(fund_step), .level_o(lvl4), .half_neg(neg4));

    pscm_level_mod #(.N_CAR(3), .PH_W(12), .CW(16)) dut3_i (
        .clk(clk), .rst(rst), .mod_idx(mod_idx), .car_half(car_half),
        .fund_step(fund_step), .level_o(lvl3), .half_neg(neg3));

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Watchdog: a hung run is reported as a failed check (R7 output flow)
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL R7 watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // R3: table sample i
    function automatic int sine_q(input int i);
        return $rtoi(65535.0 * $sin(3.14159265358979323846 * (2.0 * i + 1.0) / 1024.0) + 0.5);
    endfunction

    // R2, R3, R4: signed reference from accumulator and index
    function automatic int ref_val(input int acc, input int mi);
        int  q, i;
        longint m;
        q = (acc >> 10) & 3;
        i = (acc >> 2) & 255;
        if (q % 2 == 1) i = 255 - i;
        m = (longint'(tab[i]) * mi) / 64;
        if (m > 65535) m = 65536;
        if (q >= 2 && m != 0) return -int'(m);
        return int'(m);
    endfunction

    // R5: triangle from phase
    function automatic int car_of(input int p, input int h);
        if (p < h) return p;
        if (p <= 2 * h) return 2 * h - p;
        return 0;
    endfunction

    task automatic run_case(input string tag, input int mi, input int step,
                            input int h, input int n);
        int acc;
        int p4 [4];
        int p3 [3];
        @(negedge clk);
        rst = 1'b1;
        mod_idx = 8'(mi);
        car_half = 16'(h);
        fund_step = 12'(step);
        @(posedge clk);
        @(negedge clk);
        chk({tag, " R1 reset level n4"}, int'(lvl4), 0);
        chk({tag, " R1 reset sign n4"}, int'(neg4), 0);
        chk({tag, " R1 reset level n3"}, int'(lvl3), 0);
        chk({tag, " R1 reset sign n3"}, int'(neg3), 0);
        rst = 1'b0;
        acc = 0;
        // R6 start phases; R10 spacing for three carriers
        for (int k = 0; k < 4; k++) p4[k] = (k * 2 * h) / 4;
        for (int k = 0; k < 3; k++) p3[k] = (k * 2 * h) / 3;
        for (int t = 0; t < n; t++) begin
            int  rv, m, c4, c3, e4, e3, en;
            rv = ref_val(acc, mi);
            m  = (rv < 0) ? -rv : rv;
            en = (rv < 0) ? 1 : 0;
            c4 = 0;
            c3 = 0;
            for (int k = 0; k < 4; k++)
                if (longint'(m) * h > longint'(car_of(p4[k], h)) * 65535) c4++;
            for (int k = 0; k < 3; k++)
                if (longint'(m) * h > longint'(car_of(p3[k], h)) * 65535) c3++;
            e4 = en ? -c4 : c4;
            e3 = en ? -c3 : c3;
            @(posedge clk);
            @(negedge clk);
            chk({tag, " R6/R7 level n4"}, int'(lvl4), e4);
            chk({tag, " R8 polarity n4"}, int'(neg4), en);
            chk({tag, " R10 level n3"}, int'(lvl3), e3);
            chk({tag, " R10 polarity n3"}, int'(neg3), en);
            if (int'(lvl4) > max4) max4 = int'(lvl4);
            if (int'(lvl4) < min4) min4 = int'(lvl4);
            if (int'(lvl3) > max3) max3 = int'(lvl3);
            if (int'(lvl3) < min3) min3 = int'(lvl3);
            if (lvl4 != 0 || neg4 || lvl3 != 0 || neg3) nonzero++;
            acc = (acc + step) & 4095;
            for (int k = 0; k < 4; k++) p4[k] = (p4[k] >= 2 * h - 1) ? 0 : p4[k] + 1;
            for (int k = 0; k < 3; k++) p3[k] = (p3[k] >= 2 * h - 1) ? 0 : p3[k] + 1;
        end
    endtask

    initial begin
        for (int i = 0; i < 256; i++) tab[i] = sine_q(i);

        // R2, R3, R5, R7: nominal index, even half-period
        run_case("nominal", 64, 16, 6, 600);
        // R6: odd half-period, low index
        run_case("low", 45, 41, 5, 600);

        // R9: over-modulation reaches both extremes
        max4 = -9; min4 = 9; max3 = -9; min3 = 9;
        run_case("overmod", 70, 16, 6, 600);
        chk("R9 top level n4", max4, 4);
        chk("R9 bottom level n4", min4, -4);
        chk("R9 top level n3", max3, 3);
        chk("R9 bottom level n3", min3, -3);

        // R8: zero index gives level 0 with positive polarity throughout
        nonzero = 0;
        run_case("zero", 0, 23, 6, 300);
        chk("R8 zero reference outputs", nonzero, 0);

        // R4: largest index saturates into the clip value
        run_case("saturate", 255, 16, 7, 400);

        // R2: zero step holds the phase at the first table slot
        run_case("still", 64, 0, 6, 100);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule